// File: doc/BRIEF.md
# Second-Level Cache Control Register

This block holds the 32-bit control word of a second-level cache and turns its fields into the signals the rest of the cache needs. A privileged agent writes the word and reads it back. The block decodes the size, clock-ratio and RAM-type codes and drives them out. It enables the cache at transaction boundaries. It generates and checks byte parity for the data RAM. It also decides, for each fill request, whether a hit is serviced and whether a miss may allocate a line.

Two fields carry policy. The data-only and instruction-only filter bits restrict which side may allocate, and setting both locks the cache against any new allocation. The global-invalidate bit starts a walk over every tag index that clears the status bits one index per clock. Software can poll the bit, which returns to zero when the walk ends. A request to invalidate while the cache is enabled is refused and raises a sticky error flag.

Bit numbering below counts from the least significant bit (bit 31 is the most significant). Implemented bits are: enable 31, parity enable 30, size 29:28, clock ratio 27:25, RAM type 24:23, data-only 22, invalidate 21, instruction-only 10. All other bits are reserved.

Top module: `cache_ctl_reg`

## Requirements
- R1: After reset the register reads 0, and cache_active, inval_busy, inval_err and tag_clr_en are all 0.
- R2: size_code, clk_ratio, ram_type and parity_en follow register bits 29:28, 27:25, 24:23 and 30 from the clock edge that writes them.
- R3: A write with wr_super low leaves the register unchanged.
- R4: rd_data returns the implemented bits as stored, and reserved bits read 0. Bit 21 reads 1 from the accepted write until the invalidate walk finishes.
- R5: cache_active takes the value of enable bit 31 only on a clock edge where txn_start is high, and holds otherwise.
- R6: ram_wpar bit b is the even parity (XOR) of ram_wdata byte b when parity is enabled, and 0 otherwise. par_err is high when ram_rvalid is high, parity is enabled and ram_rpar differs from the parity of ram_rdata. par_err is 0 when parity is disabled.
- R7: With cache_active high, a request with fill_hit high raises hit_svc and never alloc_grant. A miss raises alloc_grant unless it is filtered. With cache_active low, both outputs are 0.
- R8: With data-only (bit 22) alone, instruction-side misses (fill_instr=1) are not allocated, while instruction hits are serviced and data misses allocate. With instruction-only (bit 10) alone, data-side misses are not allocated.
- R9: With bits 22 and 10 both set, no miss from either side allocates, and hits are still serviced.
- R10: A write that sets bit 21 while the stored enable bit or the written enable bit is 1 stores the other fields, stores bit 21 as 0, starts no walk and sets inval_err.
- R11: An accepted invalidate raises inval_busy and tag_clr_en one cycle after the write, for exactly 2^IDX_W cycles, with tag_clr_idx counting 0 up to 2^IDX_W-1. Bit 21 clears on the edge that ends the walk.
- R12: Writes arriving while bit 21 is set are dropped.
- R13: inval_err, once set, stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hard reset |
| wr_en | input | 1 | Register write strobe |
| wr_super | input | 1 | Write comes from the privileged level |
| wr_data | input | 32 | Write value |
| rd_data | output | 32 | Current register value |
| txn_start | input | 1 | Marks a transaction boundary where enable is sampled |
| cache_active | output | 1 | Effective enable; gates lookups and snoops |
| parity_en | output | 1 | Data parity enable |
| size_code | output | 2 | Size code |
| clk_ratio | output | 3 | Core-to-cache clock ratio code |
| ram_type | output | 2 | Data RAM type code |
| fill_req | input | 1 | Fill or lookup request |
| fill_instr | input | 1 | Request comes from the instruction side |
| fill_hit | input | 1 | Request hit in the tags |
| hit_svc | output | 1 | Hit is serviced |
| alloc_grant | output | 1 | Miss may allocate a line |
| ram_wdata | input | RAM_W | Data written to the RAM |
| ram_wpar | output | RAM_W/8 | Generated byte parity |
| ram_rvalid | input | 1 | Read data is valid |
| ram_rdata | input | RAM_W | Data read from the RAM |
| ram_rpar | input | RAM_W/8 | Parity read from the RAM |
| par_err | output | 1 | Read parity mismatch |
| inval_busy | output | 1 | Invalidate walk in progress |
| inval_err | output | 1 | Sticky flag for a refused invalidate |
| tag_clr_en | output | 1 | Clear status bits at tag_clr_idx |
| tag_clr_idx | output | IDX_W | Tag index being cleared |

## Verification
The filter is swept over every combination of the two filter bits, request side and hit/miss, both with the cache active and with it inactive. This sweep separates the data-only, instruction-only and lock cases from each other and from plain hit/miss service. The field decode is swept over all size, ratio and RAM-type codes, so a swapped or shifted field shows up. Parity runs over many data words with parity enabled and disabled, and every other read injects a one-bit parity flip. The invalidate path is tried three ways: an accepted walk with a write injected mid-walk, a refusal caused by the stored enable, and a refusal caused by the written enable. Together these separate the start timing, the walk length, the dropping of writes and the error flag.

// File: rtl/cache_ctl_pkg.sv
package cache_ctl_pkg;
   localparam int CR_W      = 32;
   localparam int B_EN      = 31;
   localparam int B_PAR     = 30;
   localparam int B_SIZE_LO = 28;
   localparam int B_CLK_LO  = 25;
   localparam int B_RAM_LO  = 23;
   localparam int B_DONLY   = 22;
   localparam int B_INV     = 21;
   localparam int B_IONLY   = 10;
   localparam logic [CR_W-1:0] CR_MASK = 32'hFFE0_0400;

   typedef struct packed {
      logic       en;
      logic       par;
      logic [1:0] size;
      logic [2:0] ratio;
      logic [1:0] ram;
      logic       donly;
      logic       inv;
      logic       ionly;
   } cr_fields_t;

   function automatic cr_fields_t cr_unpack(input logic [CR_W-1:0] w);
      cr_fields_t f;
      f.en    = w[B_EN];
      f.par   = w[B_PAR];
      f.size  = w[B_SIZE_LO +: 2];
      f.ratio = w[B_CLK_LO +: 3];
      f.ram   = w[B_RAM_LO +: 2];
      f.donly = w[B_DONLY];
      f.inv   = w[B_INV];
      f.ionly = w[B_IONLY];
      return f;
   endfunction
endpackage

// File: rtl/ccr_regfile.sv
module ccr_regfile
   import cache_ctl_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic            wr_super,
   input  logic [CR_W-1:0] wr_data,
   input  logic            inv_done,
   output logic [CR_W-1:0] cr_q,
   output logic            err_q
);
   logic            wr_ok;
   logic            refuse;
   logic [CR_W-1:0] wr_val;

   // A pending or running invalidate owns the register until it completes.
   always_comb begin
      wr_ok  = wr_en && wr_super && !cr_q[B_INV];
      wr_val = wr_data & CR_MASK;
      refuse = wr_val[B_INV] && (wr_val[B_EN] || cr_q[B_EN]);
      if (refuse) wr_val[B_INV] = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cr_q  <= '0;
         err_q <= 1'b0;
      end else if (inv_done) begin
         cr_q[B_INV] <= 1'b0;
      end else if (wr_ok) begin
         cr_q <= wr_val;
         if (refuse) err_q <= 1'b1;
      end
   end
endmodule

// File: rtl/ccr_inval_seq.sv
module ccr_inval_seq #(
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inv_req,
   output logic             busy,
   output logic [IDX_W-1:0] idx,
   output logic             done
);
   localparam logic [IDX_W-1:0] LAST = {IDX_W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         idx  <= '0;
      end else if (!busy) begin
         if (inv_req) begin
            busy <= 1'b1;
            idx  <= '0;
         end
      end else if (idx == LAST) begin
         busy <= 1'b0;
      end else begin
         idx <= idx + 1'b1;
      end
   end

   assign done = busy && (idx == LAST);
endmodule

// File: rtl/ccr_alloc_filter.sv
module ccr_alloc_filter (
   input  logic clk,
   input  logic rst_n,
   input  logic txn_start,
   input  logic en_bit,
   input  logic donly,
   input  logic ionly,
   input  logic fill_req,
   input  logic fill_instr,
   input  logic fill_hit,
   output logic active,
   output logic hit_svc,
   output logic alloc_grant
);
   logic blocked;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         active <= 1'b0;
      else if (txn_start) active <= en_bit;
   end

   always_comb begin
      blocked = (donly && ionly)
             || (donly && fill_instr)
             || (ionly && !fill_instr);
      hit_svc     = fill_req && active && fill_hit;
      alloc_grant = fill_req && active && !fill_hit && !blocked;
   end
endmodule

// File: rtl/ccr_parity.sv
module ccr_parity #(
   parameter int RAM_W   = 64,
   parameter bit PAR_ODD = 1'b0
) (
   input  logic               par_on,
   input  logic [RAM_W-1:0]   wdata,
   output logic [RAM_W/8-1:0] wpar,
   input  logic               rvalid,
   input  logic [RAM_W-1:0]   rdata,
   input  logic [RAM_W/8-1:0] rpar,
   output logic               err
);
   localparam int NB = RAM_W / 8;
   logic [NB-1:0] rcalc;

   for (genvar b = 0; b < NB; b++) begin : g_lane
      if (PAR_ODD) begin : g_odd
         assign wpar[b]  = par_on & ~(^wdata[8*b +: 8]);
         assign rcalc[b] = ~(^rdata[8*b +: 8]);
      end else begin : g_even
         assign wpar[b]  = par_on & (^wdata[8*b +: 8]);
         assign rcalc[b] = ^rdata[8*b +: 8];
      end
   end

   assign err = par_on && rvalid && (rcalc != rpar);
endmodule

// File: rtl/cache_ctl_reg.sv
module cache_ctl_reg
   import cache_ctl_pkg::*;
#(
   parameter int IDX_W   = 4,
   parameter int RAM_W   = 64,
   parameter bit PAR_ODD = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic               wr_super,
   input  logic [31:0]        wr_data,
   output logic [31:0]        rd_data,
   input  logic               txn_start,
   output logic               cache_active,
   output logic               parity_en,
   output logic [1:0]         size_code,
   output logic [2:0]         clk_ratio,
   output logic [1:0]         ram_type,
   input  logic               fill_req,
   input  logic               fill_instr,
   input  logic               fill_hit,
   output logic               hit_svc,
   output logic               alloc_grant,
   input  logic [RAM_W-1:0]   ram_wdata,
   output logic [RAM_W/8-1:0] ram_wpar,
   input  logic               ram_rvalid,
   input  logic [RAM_W-1:0]   ram_rdata,
   input  logic [RAM_W/8-1:0] ram_rpar,
   output logic               par_err,
   output logic               inval_busy,
   output logic               inval_err,
   output logic               tag_clr_en,
   output logic [IDX_W-1:0]   tag_clr_idx
);
   if (IDX_W < 1 || IDX_W > 12) begin : g_chk_idx
      $error("IDX_W must lie in 1..12");
   end
   if (RAM_W < 8 || (RAM_W % 8) != 0) begin : g_chk_ram
      $error("RAM_W must be a positive multiple of 8");
   end

   logic [CR_W-1:0] cr_q;
   cr_fields_t      f;
   logic            inv_done;

   ccr_regfile u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_super(wr_super),
      .wr_data(wr_data), .inv_done(inv_done), .cr_q(cr_q), .err_q(inval_err)
   );

   assign f = cr_unpack(cr_q);

   ccr_inval_seq #(.IDX_W(IDX_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .inv_req(f.inv),
      .busy(inval_busy), .idx(tag_clr_idx), .done(inv_done)
   );

   ccr_alloc_filter u_filt (
      .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .en_bit(f.en),
      .donly(f.donly), .ionly(f.ionly), .fill_req(fill_req),
      .fill_instr(fill_instr), .fill_hit(fill_hit), .active(cache_active),
      .hit_svc(hit_svc), .alloc_grant(alloc_grant)
   );

   ccr_parity #(.RAM_W(RAM_W), .PAR_ODD(PAR_ODD)) u_par (
      .par_on(f.par), .wdata(ram_wdata), .wpar(ram_wpar),
      .rvalid(ram_rvalid), .rdata(ram_rdata), .rpar(ram_rpar), .err(par_err)
   );

   assign rd_data    = cr_q;
   assign parity_en  = f.par;
   assign size_code  = f.size;
   assign clk_ratio  = f.ratio;
   assign ram_type   = f.ram;
   assign tag_clr_en = inval_busy;
endmodule

// File: rtl/cache_ctl_reg_chk.sv
module cache_ctl_reg_chk #(
   parameter int IDX_W = 4,
   parameter int NB    = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic             wr_super,
   input logic [31:0]      rd_data,
   input logic             txn_start,
   input logic             cache_active,
   input logic             parity_en,
   input logic             fill_req,
   input logic             fill_instr,
   input logic             fill_hit,
   input logic             alloc_grant,
   input logic [NB-1:0]    ram_wpar,
   input logic             par_err,
   input logic             inval_busy,
   input logic             inval_err,
   input logic [IDX_W-1:0] tag_clr_idx
);
   p_user_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && !wr_super && !rd_data[21] |=> rd_data == $past(rd_data));

   p_active_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !txn_start |=> $stable(cache_active));

   p_par_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !parity_en |-> (ram_wpar == '0) && !par_err);

   p_hit_no_alloc_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fill_hit |-> !alloc_grant);

   p_donly_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fill_req && fill_instr && rd_data[22] |-> !alloc_grant);

   p_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[22] && rd_data[10] |-> !alloc_grant);

   p_no_walk_enabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
      inval_busy |-> !rd_data[31]);

   p_walk_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(inval_busy) |-> tag_clr_idx == '0);

   p_walk_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
      inval_busy && $past(inval_busy) |-> tag_clr_idx == $past(tag_clr_idx) + 1'b1);

   p_busy_bit_r11: assert property (@(posedge clk) disable iff (!rst_n)
      inval_busy |-> rd_data[21]);

   p_err_sticky_r13: assert property (@(posedge clk) disable iff (!rst_n)
      inval_err |=> inval_err);
endmodule

bind cache_ctl_reg cache_ctl_reg_chk #(.IDX_W(IDX_W), .NB(RAM_W/8)) i_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_super(wr_super),
   .rd_data(rd_data), .txn_start(txn_start), .cache_active(cache_active),
   .parity_en(parity_en), .fill_req(fill_req), .fill_instr(fill_instr),
   .fill_hit(fill_hit), .alloc_grant(alloc_grant), .ram_wpar(ram_wpar),
   .par_err(par_err), .inval_busy(inval_busy), .inval_err(inval_err),
   .tag_clr_idx(tag_clr_idx)
);

// File: tb/test_cache_ctl_reg.sv
`timescale 1ns/1ps
module test_cache_ctl_reg;
   localparam int IDX_W = 4;
   localparam int RAM_W = 64;
   localparam int NB    = RAM_W / 8;
   localparam int NIDX  = 1 << IDX_W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0, wr_super = 1'b0;
   logic [31:0] wr_data = '0, rd_data;
   logic txn_start = 1'b0, cache_active, parity_en;
   logic [1:0] size_code, ram_type;
   logic [2:0] clk_ratio;
   logic fill_req = 1'b0, fill_instr = 1'b0, fill_hit = 1'b0, hit_svc, alloc_grant;
   logic [RAM_W-1:0] ram_wdata = '0, ram_rdata = '0;
   logic [NB-1:0] ram_wpar, ram_rpar = '0;
   logic ram_rvalid = 1'b0, par_err;
   logic inval_busy, inval_err, tag_clr_en;
   logic [IDX_W-1:0] tag_clr_idx;

   int n_chk = 0, n_fail = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   cache_ctl_reg #(.IDX_W(IDX_W), .RAM_W(RAM_W)) i_cache_ctl_reg (.*);

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [31:0] v, input logic sup);
      @(negedge clk);
      wr_en = 1'b1; wr_super = sup; wr_data = v;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic txn();
      @(negedge clk); txn_start = 1'b1;
      @(negedge clk); txn_start = 1'b0;
   endtask

   function automatic logic [NB-1:0] par_of(input logic [RAM_W-1:0] d);
      logic [NB-1:0] p;
      for (int b = 0; b < NB; b++) p[b] = ^d[8*b +: 8];
      return p;
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 rd_data", rd_data, 0);
      chk("R1 flags", {cache_active, inval_busy, inval_err, tag_clr_en}, 0);

      // R2 / R4 field decode sweep
      for (int s = 0; s < 4; s++)
         for (int r = 0; r < 8; r++)
            for (int m = 0; m < 4; m++) begin
               logic [31:0] v;
               v = (32'(s) << 28) | (32'(r) << 25) | (32'(m) << 23) | (32'(r & 1) << 30);
               wr(v, 1'b1);
               chk("R2 size", size_code, s);
               chk("R2 ratio", clk_ratio, r);
               chk("R2 ram", ram_type, m);
               chk("R2 parity_en", parity_en, r & 1);
               chk("R4 readback", rd_data, v);
            end

      // R3 unprivileged write dropped
      wr(32'h0000_0000, 1'b1);
      wr(32'hFFFF_FFFF, 1'b0);
      chk("R3 user write", rd_data, 0);

      // R5 enable only at transaction boundary
      wr(32'h8000_0000, 1'b1);
      chk("R5 before txn", cache_active, 0);
      repeat (3) @(negedge clk);
      chk("R5 still held", cache_active, 0);
      txn();
      chk("R5 after txn", cache_active, 1);

      // R7 R8 R9 filter sweep with cache active
      for (int d = 0; d < 2; d++)
         for (int io = 0; io < 2; io++) begin
            wr(32'h8000_0000 | (32'(d) << 22) | (32'(io) << 10), 1'b1);
            for (int ins = 0; ins < 2; ins++)
               for (int h = 0; h < 2; h++) begin
                  logic ea;
                  @(negedge clk);
                  fill_req = 1'b1; fill_instr = ins[0]; fill_hit = h[0];
                  #1;
                  ea = !h[0] && !(d == 1 && io == 1) && !(d == 1 && ins == 1)
                       && !(io == 1 && ins == 0);
                  if (d == 1 && io == 1) begin
                     chk("R9 lock alloc", alloc_grant, ea);
                     chk("R9 lock hit", hit_svc, h);
                  end else if (d == 1 || io == 1) begin
                     chk("R8 filter alloc", alloc_grant, ea);
                     chk("R8 filter hit", hit_svc, h);
                  end else begin
                     chk("R7 alloc", alloc_grant, ea);
                     chk("R7 hit", hit_svc, h);
                  end
               end
            fill_req = 1'b0;
         end

      // R5 disable at boundary, R7 inactive gives nothing
      wr(32'h0000_0000, 1'b1);
      chk("R5 held on", cache_active, 1);
      txn();
      chk("R5 off", cache_active, 0);
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         fill_req = 1'b1; fill_instr = k[0]; fill_hit = k[1];
         #1;
         chk("R7 inactive", {hit_svc, alloc_grant}, 0);
      end
      fill_req = 1'b0;

      // R6 parity enabled sweep with injected errors
      wr(32'h4000_0000, 1'b1);
      for (int j = 0; j < 64; j++) begin
         logic [RAM_W-1:0] dv;
         logic [NB-1:0] flip;
         dv = (64'h0123_4567_89AB_CDEF * 64'(j + 1)) ^ {8{8'(j)}};
         flip = (j % 2 == 1) ? NB'(1 << (j % NB)) : '0;
         @(negedge clk);
         ram_wdata = dv; ram_rdata = dv; ram_rpar = par_of(dv) ^ flip; ram_rvalid = 1'b1;
         #1;
         chk("R6 wpar", ram_wpar, par_of(dv));
         chk("R6 perr", par_err, j % 2);
      end
      wr(32'h0000_0000, 1'b1);
      for (int j = 0; j < 8; j++) begin
         @(negedge clk);
         ram_wdata = 64'hA5A5_0F0F_1234_5678 + 64'(j * 977); ram_rpar = NB'(j + 1);
         #1;
         chk("R6 disabled", {ram_wpar, par_err}, 0);
      end
      ram_rvalid = 1'b0;

      // R11 accepted walk, R12 write injected mid-walk
      wr(32'h0020_0000 | (32'd3 << 25), 1'b1);
      chk("R4 inv bit pending", rd_data, 32'h0620_0000);
      chk("R11 not yet busy", {inval_busy, tag_clr_en}, 0);
      for (int k = 0; k < NIDX; k++) begin
         @(negedge clk);
         wr_en = (k == 2); wr_super = 1'b1; wr_data = 32'hFFFF_FFFF;
         chk("R11 busy", {inval_busy, tag_clr_en}, 2'b11);
         chk("R11 index", tag_clr_idx, k);
         chk("R4 inv bit live", rd_data[21], 1);
      end
      wr_en = 1'b0;
      @(negedge clk);
      chk("R11 walk ended", {inval_busy, tag_clr_en}, 0);
      chk("R12 dropped write", rd_data, 32'h0600_0000);
      chk("R13 no error yet", inval_err, 0);

      // R10 refused by stored enable
      wr(32'h8000_0000, 1'b1);
      wr(32'h0020_0000 | (32'd1 << 28), 1'b1);
      chk("R10 stored-enable refuse", rd_data, 32'h1000_0000);
      chk("R10 error set", inval_err, 1);
      @(negedge clk);
      chk("R10 no walk", {inval_busy, tag_clr_en}, 0);

      // R10 refused by written enable, R4 reserved bits read zero
      wr(32'hFFFF_FFFF, 1'b1);
      chk("R4 reserved zero", rd_data, 32'hFFC0_0400);
      @(negedge clk);
      chk("R10 no walk2", inval_busy, 0);

      // R13 sticky after normal writes
      wr(32'h0000_0000, 1'b1);
      repeat (4) @(negedge clk);
      chk("R13 sticky", inval_err, 1);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule